// File: doc/BRIEF.md
# Task Gate Dispatch Controller

This block switches a processing element between hardware tasks when an event is steered to a task-style handler gate. Each task owns a slot in a small context store. A slot holds the task's step counter, its interrupt-enable flag and its nested flag. A side table keeps a busy bit and a back-link index for every task. On a dispatch request the controller first checks the busy bit of the target. If the target is free, it writes the running task's live context into that task's own slot. It then loads the handler's context, marks the handler as nested and records which task it interrupted.

A return request from the running task latches the live nested flag and clears it. The task's context is saved with the step counter advanced past the return, so that the next dispatch of a handler resumes just after its return. If the latched flag was set, the controller clears the leaving task's busy bit and resumes the task named by the back-link. Otherwise the return is a plain one and execution continues in the same task. A dispatch request that arrives while a switch is in progress is held in a one-deep slot and served as soon as the controller is idle again.

Top module: `task_gate_switch`

## Requirements
- R1: After reset, task BOOT_TASK (index 0 by default) runs with step counter 0 and nested flag 0. Only that task's bit is set in `busy_vec`. `sw_idle` is 1 and `fault` is 0. Every slot's interrupt-enable flag takes bit i of parameter IE_INIT (default 4'b0101, so tasks 0 and 2 are enabled).
- R2: A dispatch accepted at a clock edge holds `sw_idle` low for exactly two cycles. At the second edge after acceptance, `cur_task` becomes the target and `cur_nested` becomes 1, and the target's bit in `busy_vec` is set.
- R3: After a dispatch, `cur_link` shows the index of the task that was running when the dispatch was accepted.
- R4: On a switch, `cur_ie` takes the value held in the loaded task's slot. The gate never forces it.
- R5: A dispatch whose target has its busy bit set does not switch. It raises `fault` for one cycle, with `fault_task` giving the target, and leaves the running task and its step counter unchanged.
- R6: A task that is interrupted and later resumed continues with the step counter, interrupt-enable flag and nested flag it had when it was interrupted.
- R7: A return taken while `cur_nested` is 1 completes two cycles after acceptance. It clears the leaving task's busy bit, resumes the back-link task with its saved context, and sets that task's busy bit.
- R8: A return taken while `cur_nested` is 0 keeps the same task running. The step counter advances by one, `cur_nested` is 0 and `busy_vec` is unchanged.
- R9: On every return, the leaving task's slot is stored with the step counter plus one and the nested flag cleared. A later dispatch of that task starts from that value.
- R10: A dispatch request presented while `sw_idle` is 0 is held in a single pending slot. It is served on the first idle cycle. A further request that arrives while the slot is full is dropped.
- R11: In an idle cycle, a pending or new dispatch takes precedence over `ret_req`, and that return request is dropped. `ret_req` is also dropped when `sw_idle` is 0. `step_en` advances the step counter only in an idle cycle where neither a dispatch, a fault nor a return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Dispatch request to a task-style gate |
| evt_task | input | IDX_W | Handler task index of the request |
| ret_req | input | 1 | Return request from the running task |
| step_en | input | 1 | Running task advances one step |
| cur_task | output | IDX_W | Index of the running task |
| cur_pc | output | PC_W | Live step counter of the running task |
| cur_ie | output | 1 | Live interrupt-enable flag |
| cur_nested | output | 1 | Live nested flag |
| cur_link | output | IDX_W | Back-link entry of the running task |
| busy_vec | output | NUM_TASKS | Busy bit per task |
| sw_idle | output | 1 | No switch or return in progress |
| fault | output | 1 | One-cycle busy-target fault pulse |
| fault_task | output | IDX_W | Target index of the last fault |

## Verification
The properties assume that `evt_task` always names an existing task. With a power-of-two task count this holds for every value. The bench draws its indices only from 0 to NUM_TASKS-1. The properties also assume that the slot contents come only from the controller's own saves, so a nested running task always points back at a busy task. The bench never touches the store except through dispatches and returns. Random stimulus mixes requests freely during switches, so that the pending slot, dropped returns and faults on busy tasks all occur.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_LOAD,
        ST_RSAVE,
        ST_RLOAD
    } tgs_state_e;

endpackage

// File: rtl/tgs_ctx_store.sv
module tgs_ctx_store #(
    parameter int NUM_TASKS = 4,
    parameter int PC_W = 8,
    parameter logic [NUM_TASKS-1:0] IE_INIT = 4'b0101,
    localparam int IDX_W = $clog2(NUM_TASKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic             wr_ie,
    input  logic             wr_nt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PC_W-1:0]  rd_pc,
    output logic             rd_ie,
    output logic             rd_nt
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            ie;
        logic            nt;
    } slot_t;

    slot_t slots [NUM_TASKS];

    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot_d.pc = wr_pc;
                slot_d.ie = wr_ie;
                slot_d.nt = wr_nt;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q.pc <= '0;
                slot_q.ie <= IE_INIT[i];
                slot_q.nt <= 1'b0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slots[i] = slot_q;
    end

    assign rd_pc = slots[rd_idx].pc;
    assign rd_ie = slots[rd_idx].ie;
    assign rd_nt = slots[rd_idx].nt;

endmodule

// File: rtl/tgs_link_table.sv
module tgs_link_table #(
    parameter int NUM_TASKS = 4,
    parameter int BOOT_TASK = 0,
    localparam int IDX_W = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_idx,
    input  logic [IDX_W-1:0]     set_link,
    input  logic                 mark_en,
    input  logic [IDX_W-1:0]     mark_idx,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [IDX_W-1:0]     rd_link,
    output logic [NUM_TASKS-1:0] busy_vec
);

    localparam logic [NUM_TASKS-1:0] BUSY_RST = NUM_TASKS'(1) << BOOT_TASK;

    typedef struct packed {
        logic [NUM_TASKS-1:0]            busy;
        logic [NUM_TASKS-1:0][IDX_W-1:0] link;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clr_en) begin
            tbl_d.busy[clr_idx] = 1'b0;
        end
        if (mark_en) begin
            tbl_d.busy[mark_idx] = 1'b1;
        end
        if (set_en) begin
            tbl_d.busy[set_idx] = 1'b1;
            tbl_d.link[set_idx] = set_link;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.busy <= BUSY_RST;
            tbl_q.link <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign busy_vec = tbl_q.busy;
    assign rd_link  = tbl_q.link[rd_idx];

endmodule

// File: rtl/tgs_ctrl.sv
module tgs_ctrl
    import tgs_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int PC_W = 8,
    parameter int BOOT_TASK = 0,
    parameter logic [NUM_TASKS-1:0] IE_INIT = 4'b0101,
    localparam int IDX_W = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [IDX_W-1:0]     evt_task,
    input  logic                 ret_req,
    input  logic                 step_en,
    input  logic [NUM_TASKS-1:0] busy_vec,
    input  logic [IDX_W-1:0]     cur_link,
    input  logic [PC_W-1:0]      slot_pc,
    input  logic                 slot_ie,
    input  logic                 slot_nt,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [PC_W-1:0]      wr_pc,
    output logic                 wr_ie,
    output logic                 wr_nt,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 set_en,
    output logic [IDX_W-1:0]     set_idx,
    output logic [IDX_W-1:0]     set_link,
    output logic                 mark_en,
    output logic [IDX_W-1:0]     mark_idx,
    output logic                 clr_en,
    output logic [IDX_W-1:0]     clr_idx,
    output logic [IDX_W-1:0]     cur_task,
    output logic [PC_W-1:0]      cur_pc,
    output logic                 cur_ie,
    output logic                 cur_nested,
    output logic                 sw_idle,
    output logic                 fault,
    output logic [IDX_W-1:0]     fault_task
);

    typedef struct packed {
        tgs_state_e      state;
        logic [IDX_W-1:0] cur;
        logic [PC_W-1:0]  pc;
        logic             ie;
        logic             nt;
        logic [IDX_W-1:0] tgt;
        logic             pend;
        logic [IDX_W-1:0] pend_task;
        logic             nt_latch;
        logic             fault;
        logic [IDX_W-1:0] fault_task;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic             have_disp;
    logic [IDX_W-1:0] disp_task;

    assign have_disp = c_q.pend | evt_valid;
    assign disp_task = c_q.pend ? c_q.pend_task : evt_task;

    always_comb begin
        c_d      = c_q;
        c_d.fault = 1'b0;

        wr_en    = 1'b0;
        wr_idx   = c_q.cur;
        wr_pc    = c_q.pc;
        wr_ie    = c_q.ie;
        wr_nt    = c_q.nt;
        slot_idx = c_q.tgt;
        set_en   = 1'b0;
        set_idx  = c_q.tgt;
        set_link = c_q.cur;
        mark_en  = 1'b0;
        mark_idx = cur_link;
        clr_en   = 1'b0;
        clr_idx  = c_q.cur;

        // one-deep hold of requests that meet a switch in progress
        if (c_q.state != ST_IDLE && !c_q.pend && evt_valid) begin
            c_d.pend      = 1'b1;
            c_d.pend_task = evt_task;
        end

        unique case (c_q.state)
            ST_IDLE: begin
                if (have_disp) begin
                    c_d.pend      = c_q.pend & evt_valid;
                    c_d.pend_task = evt_task;
                    if (busy_vec[disp_task]) begin
                        c_d.fault      = 1'b1;
                        c_d.fault_task = disp_task;
                    end else begin
                        c_d.state = ST_SAVE;
                        c_d.tgt   = disp_task;
                    end
                end else if (ret_req) begin
                    c_d.state = ST_RSAVE;
                end else if (step_en) begin
                    c_d.pc = c_q.pc + PC_W'(1);
                end
            end
            ST_SAVE: begin
                wr_en     = 1'b1;
                c_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                slot_idx  = c_q.tgt;
                set_en    = 1'b1;
                c_d.cur   = c_q.tgt;
                c_d.pc    = slot_pc;
                c_d.ie    = slot_ie;
                c_d.nt    = 1'b1;
                c_d.state = ST_IDLE;
            end
            ST_RSAVE: begin
                wr_en        = 1'b1;
                wr_pc        = c_q.pc + PC_W'(1);
                wr_nt        = 1'b0;
                clr_en       = c_q.nt;
                c_d.nt_latch = c_q.nt;
                c_d.pc       = c_q.pc + PC_W'(1);
                c_d.nt       = 1'b0;
                c_d.state    = ST_RLOAD;
            end
            ST_RLOAD: begin
                slot_idx = cur_link;
                if (c_q.nt_latch) begin
                    mark_en = 1'b1;
                    c_d.cur = cur_link;
                    c_d.pc  = slot_pc;
                    c_d.ie  = slot_ie;
                    c_d.nt  = slot_nt;
                end
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q            <= '0;
            c_q.state      <= ST_IDLE;
            c_q.cur        <= IDX_W'(BOOT_TASK);
            c_q.ie         <= IE_INIT[BOOT_TASK];
        end else begin
            c_q <= c_d;
        end
    end

    assign cur_task   = c_q.cur;
    assign cur_pc     = c_q.pc;
    assign cur_ie     = c_q.ie;
    assign cur_nested = c_q.nt;
    assign sw_idle    = (c_q.state == ST_IDLE);
    assign fault      = c_q.fault;
    assign fault_task = c_q.fault_task;

endmodule

// File: rtl/task_gate_switch.sv
module task_gate_switch #(
    parameter int NUM_TASKS = 4,
    parameter int PC_W = 8,
    parameter int BOOT_TASK = 0,
    parameter logic [NUM_TASKS-1:0] IE_INIT = 4'b0101,
    localparam int IDX_W = $clog2(NUM_TASKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [IDX_W-1:0]     evt_task,
    input  logic                 ret_req,
    input  logic                 step_en,
    output logic [IDX_W-1:0]     cur_task,
    output logic [PC_W-1:0]      cur_pc,
    output logic                 cur_ie,
    output logic                 cur_nested,
    output logic [IDX_W-1:0]     cur_link,
    output logic [NUM_TASKS-1:0] busy_vec,
    output logic                 sw_idle,
    output logic                 fault,
    output logic [IDX_W-1:0]     fault_task
);

    logic             wr_en, wr_ie, wr_nt;
    logic [IDX_W-1:0] wr_idx, slot_idx;
    logic [PC_W-1:0]  wr_pc, slot_pc;
    logic             slot_ie, slot_nt;
    logic             set_en, mark_en, clr_en;
    logic [IDX_W-1:0] set_idx, set_link, mark_idx, clr_idx;

    tgs_ctrl #(
        .NUM_TASKS(NUM_TASKS), .PC_W(PC_W), .BOOT_TASK(BOOT_TASK), .IE_INIT(IE_INIT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_task(evt_task), .ret_req(ret_req), .step_en(step_en),
        .busy_vec(busy_vec), .cur_link(cur_link),
        .slot_pc(slot_pc), .slot_ie(slot_ie), .slot_nt(slot_nt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc), .wr_ie(wr_ie), .wr_nt(wr_nt),
        .slot_idx(slot_idx),
        .set_en(set_en), .set_idx(set_idx), .set_link(set_link),
        .mark_en(mark_en), .mark_idx(mark_idx), .clr_en(clr_en), .clr_idx(clr_idx),
        .cur_task(cur_task), .cur_pc(cur_pc), .cur_ie(cur_ie), .cur_nested(cur_nested),
        .sw_idle(sw_idle), .fault(fault), .fault_task(fault_task)
    );

    tgs_ctx_store #(
        .NUM_TASKS(NUM_TASKS), .PC_W(PC_W), .IE_INIT(IE_INIT)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc), .wr_ie(wr_ie), .wr_nt(wr_nt),
        .rd_idx(slot_idx), .rd_pc(slot_pc), .rd_ie(slot_ie), .rd_nt(slot_nt)
    );

    tgs_link_table #(
        .NUM_TASKS(NUM_TASKS), .BOOT_TASK(BOOT_TASK)
    ) links_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .set_idx(set_idx), .set_link(set_link),
        .mark_en(mark_en), .mark_idx(mark_idx), .clr_en(clr_en), .clr_idx(clr_idx),
        .rd_idx(cur_task), .rd_link(cur_link), .busy_vec(busy_vec)
    );

endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
    parameter int NUM_TASKS = 4,
    parameter int PC_W = 8,
    localparam int IDX_W = $clog2(NUM_TASKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IDX_W-1:0]     cur_task,
    input logic [PC_W-1:0]      cur_pc,
    input logic                 cur_nested,
    input logic [IDX_W-1:0]     cur_link,
    input logic [NUM_TASKS-1:0] busy_vec,
    input logic                 sw_idle,
    input logic                 fault
);

    AST_SWITCH_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_idle) |=> !sw_idle); // R2

    AST_TASK_HELD_MID_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_idle && $past(!sw_idle)) |-> $stable(cur_task)); // R2

    AST_RUNNING_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_idle |-> busy_vec[cur_task]); // R7

    AST_LINK_TARGET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_idle && cur_nested) |-> busy_vec[cur_link]); // R3

    AST_FAULT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(sw_idle) && sw_idle)); // R5

    AST_FAULT_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (cur_task == $past(cur_task) && cur_pc == $past(cur_pc))); // R5

endmodule

bind task_gate_switch tgs_checker #(.NUM_TASKS(NUM_TASKS), .PC_W(PC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cur_task(cur_task), .cur_pc(cur_pc),
    .cur_nested(cur_nested), .cur_link(cur_link), .busy_vec(busy_vec),
    .sw_idle(sw_idle), .fault(fault)
);

// File: tb/task_gate_switch_tb_top.sv
module task_gate_switch_tb_top;

    localparam int NT = 4;
    localparam int PW = 8;
    localparam int IW = 2;
    localparam int MASK = (1 << PW) - 1;
    localparam logic [NT-1:0] IEM = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0, ret_req = 1'b0, step_en = 1'b0;
    logic [IW-1:0] evt_task = '0;
    logic [IW-1:0] cur_task, cur_link, fault_task;
    logic [PW-1:0] cur_pc;
    logic cur_ie, cur_nested, sw_idle, fault;
    logic [NT-1:0] busy_vec;

    always #2 clk = ~clk;

    task_gate_switch #(.NUM_TASKS(NT), .PC_W(PW), .BOOT_TASK(0), .IE_INIT(IEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_task(evt_task),
        .ret_req(ret_req), .step_en(step_en), .cur_task(cur_task), .cur_pc(cur_pc),
        .cur_ie(cur_ie), .cur_nested(cur_nested), .cur_link(cur_link),
        .busy_vec(busy_vec), .sw_idle(sw_idle), .fault(fault), .fault_task(fault_task)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural reference model
    int m_pc[NT], m_ie[NT], m_nt[NT], m_link[NT], m_busy[NT];
    int cur = 0, lpc = 0, lie = 1, lnt = 0;
    int cnt = 0, op = 0, tgt = 0, pend_v = 0, pend_t = 0, f_e = 0, f_t = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin
            m_pc[i] = 0; m_ie[i] = int'(IEM[i]); m_nt[i] = 0; m_link[i] = 0; m_busy[i] = 0;
        end
        m_busy[0] = 1;
        cur = 0; lpc = 0; lie = int'(IEM[0]); lnt = 0;
        cnt = 0; pend_v = 0; f_e = 0;
    endtask

    task automatic model_apply();
        if (op == 1) begin
            m_pc[cur] = lpc; m_ie[cur] = lie; m_nt[cur] = lnt;
            m_link[tgt] = cur; m_busy[tgt] = 1;
            cur = tgt; lpc = m_pc[tgt]; lie = m_ie[tgt]; lnt = 1;
        end else begin
            int was = lnt;
            lpc = (lpc + 1) & MASK;
            m_pc[cur] = lpc; m_ie[cur] = lie; m_nt[cur] = 0; lnt = 0;
            if (was != 0) begin
                m_busy[cur] = 0;
                cur = m_link[cur];
                lpc = m_pc[cur]; lie = m_ie[cur]; lnt = m_nt[cur];
                m_busy[cur] = 1;
            end
        end
    endtask

    task automatic model_step(input int ev, input int et, input int rt, input int st);
        f_e = 0;
        if (cnt > 0) begin
            if (pend_v == 0 && ev != 0) begin pend_v = 1; pend_t = et; end
            cnt--;
            if (cnt == 0) model_apply();
        end else if (pend_v != 0 || ev != 0) begin
            int dt = (pend_v != 0) ? pend_t : et;
            if (pend_v != 0) begin pend_v = ev; pend_t = et; end
            if (m_busy[dt] != 0) begin f_e = 1; f_t = dt; end
            else begin op = 1; tgt = dt; cnt = 2; end
        end else if (rt != 0) begin
            op = 2; cnt = 2;
        end else if (st != 0) begin
            lpc = (lpc + 1) & MASK;
        end
    endtask

    task automatic compare();
        int bv = 0;
        for (int i = 0; i < NT; i++) bv |= (m_busy[i] << i);
        chk(int'(sw_idle) == int'(cnt == 0), "R2 sw_idle", int'(sw_idle), int'(cnt == 0));
        chk(int'(fault) == f_e, "R5 fault", int'(fault), f_e);
        if (f_e != 0) chk(int'(fault_task) == f_t, "R5 fault_task", int'(fault_task), f_t);
        if (cnt == 0) begin
            chk(int'(cur_task) == cur, "R2 cur_task", int'(cur_task), cur);
            chk(int'(cur_pc) == lpc, "R6 cur_pc", int'(cur_pc), lpc);
            chk(int'(cur_ie) == lie, "R4 cur_ie", int'(cur_ie), lie);
            chk(int'(cur_nested) == lnt, "R7 cur_nested", int'(cur_nested), lnt);
            chk(int'(busy_vec) == bv, "R7 busy_vec", int'(busy_vec), bv);
            if (lnt != 0)
                chk(int'(cur_link) == m_link[cur], "R3 cur_link", int'(cur_link), m_link[cur]);
        end
    endtask

    task automatic tick(input int ev, input int et, input int rt, input int st);
        evt_valid = (ev != 0); evt_task = IW'(et); ret_req = (rt != 0); step_en = (st != 0);
        @(posedge clk);
        model_step(ev, et, rt, st);
        @(negedge clk);
        compare();
    endtask

    task automatic expect_now(input string tag, input int t, input int pc, input int ie,
                              input int nt, input int bv);
        chk(int'(cur_task) == t, {tag, " task"}, int'(cur_task), t);
        chk(int'(cur_pc) == pc, {tag, " pc"}, int'(cur_pc), pc);
        chk(int'(cur_ie) == ie, {tag, " ie"}, int'(cur_ie), ie);
        chk(int'(cur_nested) == nt, {tag, " nested"}, int'(cur_nested), nt);
        chk(int'(busy_vec) == bv, {tag, " busy"}, int'(busy_vec), bv);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_now("R1", 0, 0, 1, 0, 4'b0001);
        chk(sw_idle == 1'b1, "R1 idle", int'(sw_idle), 1);
        chk(fault == 1'b0, "R1 fault", int'(fault), 0);

        repeat (3) tick(0, 0, 0, 1);
        tick(1, 2, 0, 0); tick(0, 0, 0, 1); tick(0, 0, 0, 1);
        expect_now("R2 R4 dispatch", 2, 0, 1, 1, 4'b0101);
        chk(int'(cur_link) == 0, "R3 link", int'(cur_link), 0);

        repeat (5) tick(0, 0, 0, 1);
        tick(1, 0, 0, 1);
        chk(fault == 1'b1, "R5 fault pulse", int'(fault), 1);
        chk(int'(fault_task) == 0, "R5 fault_task", int'(fault_task), 0);
        expect_now("R5 no switch", 2, 5, 1, 1, 4'b0101);
        tick(0, 0, 0, 0);
        chk(fault == 1'b0, "R5 fault one cycle", int'(fault), 0);

        tick(1, 1, 0, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R4 ie from slot", 1, 0, 0, 1, 4'b0111);
        chk(int'(cur_link) == 2, "R3 nested link", int'(cur_link), 2);

        repeat (2) tick(0, 0, 0, 1);
        tick(0, 0, 1, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R7 R6 resume", 2, 5, 1, 1, 4'b0101);
        tick(0, 0, 1, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R7 R6 resume boot", 0, 3, 1, 0, 4'b0001);

        tick(0, 0, 1, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R8 plain return", 0, 4, 1, 0, 4'b0001);

        tick(1, 1, 0, 0); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R9 resume after return", 1, 3, 0, 1, 4'b0011);

        // return, then two requests during the switch: first held, second dropped
        tick(0, 0, 1, 0); tick(1, 3, 0, 1); tick(1, 2, 0, 1);
        expect_now("R10 back on boot", 0, 4, 1, 0, 4'b0001);
        tick(0, 0, 0, 0); tick(0, 0, 0, 1); tick(0, 0, 0, 1);
        expect_now("R10 pending served", 3, 0, 0, 1, 4'b1001);
        repeat (3) tick(0, 0, 0, 0);
        chk(int'(cur_task) == 3, "R10 second request dropped", int'(cur_task), 3);

        tick(1, 1, 1, 1); tick(0, 0, 0, 0); tick(0, 0, 0, 0);
        expect_now("R11 dispatch beats return", 1, 4, 0, 1, 4'b1011);
        tick(0, 0, 0, 0);
        chk(int'(cur_task) == 1 && sw_idle, "R11 return dropped", int'(cur_task), 1);

        for (int k = 0; k < 4000; k++) begin
            int ev = ($urandom_range(0, 7) == 0);
            int rt = ($urandom_range(0, 5) == 0);
            tick(ev, $urandom_range(0, NT - 1), rt, $urandom_range(0, 1));
        end
        finish_run();
    end

endmodule